// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address by fetching two 4-byte entries from memory. The first is a directory entry, chosen by the top twelve address bits. The second is a page entry, chosen by the next eight bits from the table that the directory entry points to. The walker takes one request at a time on a ready/valid port. It reads memory through a request/response port that allows any number of stall and latency cycles. Each walk ends in a single-cycle result, which is either a successful translation with a 4-bit permission index or a fault.

A fault is raised when either entry is invalid. It sets a level-specific status bit and a bit for the requesting master, and it records the faulting address in a per-level error register. These status bits are sticky and write-one-to-clear, and they drive an interrupt line. A separate register holds one active-low reset output per master. Fault handling code can use it to keep offending masters in reset and then release them all by writing all ones.

Top module: `pt_walker`

## Requirements
- R1: After reset, walk_ready is 1, res_valid and mem_req_valid are 0, int_status is all zeros, irq is 0 and master_run_n is all ones.
- R2: The first memory read of a walk goes to base + va[31:20]*4, where base is the value of ttb_base in the cycle the walk is accepted; later changes to ttb_base do not affect a walk in progress.
- R3: A directory entry is valid only when its bits [1:0] equal 2'b01 (00, 10 and 11 are all invalid); on a valid entry the second read goes to {entry[31:10], va[19:12], 2'b00}, and reserved bits [9:2] are ignored.
- R4: A page entry is valid when bit 1 is set. On success res_valid pulses for one cycle with res_fault 0, res_pa = {entry[31:12], va[11:0]} and res_perm = entry[7:4].
- R5: On an invalid directory entry no second read is issued. res_valid pulses with res_fault 1, int_status bit 16 and bit [master] are set, err_addr_l1 takes the virtual address and err_master takes the master.
- R6: On an invalid page entry res_valid pulses with res_fault 1, int_status bit 17 and bit [master] are set, err_addr_l2 takes the virtual address and err_master takes the master.
- R7: Only one walk is in flight. walk_ready is 0 from acceptance until the cycle after the result. A memory request holds its valid and address steady until it is accepted.
- R8: int_status bits are cleared by int_clr_valid with a 1 in int_clr_mask. A bit being set in the same cycle stays set. irq equals the OR of all int_status bits.
- R9: A hold_wr_valid write loads hold_wr_data into master_run_n on the next clock. Writing all ones releases every master.
- R10: Error address registers keep their last fault value through successful walks and faults of the other level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ttb_base | input | 32 | Directory base address |
| walk_valid | input | 1 | Translation request valid |
| walk_ready | output | 1 | Walker idle, request accepted |
| walk_va | input | 32 | Virtual address to translate |
| walk_master | input | MID_W | Requesting master index |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| res_valid | output | 1 | One-cycle walk result strobe |
| res_fault | output | 1 | Result is a fault |
| res_pa | output | 32 | Translated physical address |
| res_perm | output | 4 | Permission domain index |
| int_status | output | 18 | Sticky status: bit 16 level-1 fault, bit 17 level-2 fault, low bits per master |
| int_clr_valid | input | 1 | Status clear strobe |
| int_clr_mask | input | 18 | Status bits to clear |
| irq | output | 1 | Any status bit set |
| err_addr_l1 | output | 32 | Last level-1 faulting address |
| err_addr_l2 | output | 32 | Last level-2 faulting address |
| err_master | output | MID_W | Master of the last fault |
| hold_wr_valid | input | 1 | Master reset register write strobe |
| hold_wr_data | input | NUM_MASTERS | Master reset register write value |
| master_run_n | output | NUM_MASTERS | Per-master active-low reset |

## Verification
If the walker holds a wrong latched base, table pointer or address, the error shows on mem_req_addr in the first or second read of the same walk. It reaches res_pa in the result cycle, two to a few cycles later depending on memory latency. If the sequencer takes a wrong branch, the next result pulse shows a wrong read count or a wrong fault flag. A status or error register that is updated wrongly shows at its port on the cycle after the response that caused it. The bench therefore checks read addresses, result fields and status together for every walk in a sweep. The sweep covers all four directory valid codes, valid and invalid page entries, several masters and variable memory stalls.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int NUM_MASTERS = 6,
  localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int STAT_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            ttb_base,
  input  logic                   walk_valid,
  output logic                   walk_ready,
  input  logic [31:0]            walk_va,
  input  logic [MID_W-1:0]       walk_master,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [31:0]            mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [31:0]            mem_rsp_data,
  output logic                   res_valid,
  output logic                   res_fault,
  output logic [31:0]            res_pa,
  output logic [3:0]             res_perm,
  output logic [STAT_W-1:0]      int_status,
  input  logic                   int_clr_valid,
  input  logic [STAT_W-1:0]      int_clr_mask,
  output logic                   irq,
  output logic [31:0]            err_addr_l1,
  output logic [31:0]            err_addr_l2,
  output logic [MID_W-1:0]       err_master,
  input  logic                   hold_wr_valid,
  input  logic [NUM_MASTERS-1:0] hold_wr_data,
  output logic [NUM_MASTERS-1:0] master_run_n
);
  localparam int L1_BIT = 16;
  localparam int L2_BIT = 17;

  if (NUM_MASTERS > L1_BIT) begin : g_bad_cfg
    $error("NUM_MASTERS must not exceed 16");
  end

  typedef enum logic [2:0] {
    S_IDLE, S_DTE_REQ, S_DTE_RSP, S_PTE_REQ, S_PTE_RSP, S_DONE, S_FAULT
  } st_t;

  st_t              st;
  logic [31:0]      va_q, base_q;
  logic [MID_W-1:0] mst_q;
  logic [21:0]      ptb_q;
  logic [19:0]      frame_q;
  logic [3:0]       perm_q;

  logic dte_ok, pte_ok, set_l1, set_l2;
  logic [STAT_W-1:0] set_vec, clr_vec;
  logic unused_rsv;

  assign dte_ok = mem_rsp_data[1:0] == 2'b01;
  assign pte_ok = mem_rsp_data[1];
  assign unused_rsv = ^{mem_rsp_data[9:8], mem_rsp_data[3:2]};

  assign set_l1 = (st == S_DTE_RSP) && mem_rsp_valid && !dte_ok;
  assign set_l2 = (st == S_PTE_RSP) && mem_rsp_valid && !pte_ok;

  assign walk_ready    = st == S_IDLE;
  assign mem_req_valid = (st == S_DTE_REQ) || (st == S_PTE_REQ);
  assign mem_req_addr  = (st == S_PTE_REQ) ? {ptb_q, va_q[19:12], 2'b00}
                                           : base_q + {18'd0, va_q[31:20], 2'b00};
  assign res_valid = (st == S_DONE) || (st == S_FAULT);
  assign res_fault = st == S_FAULT;
  assign res_pa    = {frame_q, va_q[11:0]};
  assign res_perm  = perm_q;
  assign irq       = |int_status;
  assign clr_vec   = int_clr_valid ? int_clr_mask : '0;

  always_comb begin
    set_vec = '0;
    set_vec[L1_BIT] = set_l1;
    set_vec[L2_BIT] = set_l2;
    if (set_l1 || set_l2) set_vec[mst_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      mst_q   <= '0;
      ptb_q   <= '0;
      frame_q <= '0;
      perm_q  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (walk_valid) begin
            va_q   <= walk_va;
            base_q <= ttb_base;
            mst_q  <= walk_master;
            st     <= S_DTE_REQ;
          end
        S_DTE_REQ: if (mem_req_ready) st <= S_DTE_RSP;
        S_DTE_RSP:
          if (mem_rsp_valid) begin
            if (dte_ok) begin
              ptb_q <= mem_rsp_data[31:10];
              st    <= S_PTE_REQ;
            end else begin
              st <= S_FAULT;
            end
          end
        S_PTE_REQ: if (mem_req_ready) st <= S_PTE_RSP;
        S_PTE_RSP:
          if (mem_rsp_valid) begin
            if (pte_ok) begin
              frame_q <= mem_rsp_data[31:12];
              perm_q  <= mem_rsp_data[7:4];
              st      <= S_DONE;
            end else begin
              st <= S_FAULT;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_status  <= '0;
      err_addr_l1 <= '0;
      err_addr_l2 <= '0;
      err_master  <= '0;
    end else begin
      int_status <= (int_status & ~clr_vec) | set_vec;
      if (set_l1) err_addr_l1 <= va_q;
      if (set_l2) err_addr_l2 <= va_q;
      if (set_l1 || set_l2) err_master <= mst_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) master_run_n <= '1;
    else if (hold_wr_valid) master_run_n <= hold_wr_data;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7
  single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_req_valid && !res_valid);

  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && walk_ready);

  // R5
  l1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DTE_RSP) && mem_rsp_valid && (mem_rsp_data[1:0] != 2'b01)
      |=> res_fault && int_status[L1_BIT] && !mem_req_valid);

  // R6
  l2_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PTE_RSP) && mem_rsp_valid && !mem_rsp_data[1]
      |=> res_fault && int_status[L2_BIT]);

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_status != '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr_valid |=> master_run_n == $past(hold_wr_data));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int NM = 6;
  localparam logic [31:0] TTB = 32'h4000_0000;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [31:0] ttb_base = TTB;
  logic walk_valid = 0, walk_ready;
  logic [31:0] walk_va = 0;
  logic [2:0] walk_master = 0;
  logic mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic res_valid, res_fault;
  logic [31:0] res_pa;
  logic [3:0] res_perm;
  logic [17:0] int_status;
  logic clr_by_task = 0, clr_by_rsp = 0;
  logic [17:0] task_mask = '1;
  logic int_clr_valid;
  logic [17:0] int_clr_mask;
  logic irq;
  logic [31:0] err_addr_l1, err_addr_l2;
  logic [2:0] err_master;
  logic hold_wr_valid = 0;
  logic [NM-1:0] hold_wr_data = 0, master_run_n;

  assign int_clr_valid = clr_by_task | clr_by_rsp;
  assign int_clr_mask  = clr_by_task ? task_mask : '1;

  pt_walker #(.NUM_MASTERS(NM)) uut (
    .clk(clk), .rst_n(rst_n), .ttb_base(ttb_base),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_va(walk_va),
    .walk_master(walk_master), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_pa(res_pa),
    .res_perm(res_perm), .int_status(int_status),
    .int_clr_valid(int_clr_valid), .int_clr_mask(int_clr_mask), .irq(irq),
    .err_addr_l1(err_addr_l1), .err_addr_l2(err_addr_l2),
    .err_master(err_master), .hold_wr_valid(hold_wr_valid),
    .hold_wr_data(hold_wr_data), .master_run_n(master_run_n));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dte_word(input logic [11:0] idx);
    return {2'b10, idx, 8'h00, 8'hA5, idx[1:0]};
  endfunction

  function automatic logic [31:0] pte_word(input logic [31:0] a);
    return {a[21:2] ^ 20'h5A5A5, 4'hC, a[9:6], 2'b11, a[3], 1'b1};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a[31:30] == 2'b10) return pte_word(a);
    return dte_word(a[13:2]);
  endfunction

  // memory model: variable ready stalls and response latency
  int rd_total = 0;
  logic [31:0] rd_log [4];
  logic [31:0] pend_addr = 0;
  int lat_cnt = -1;
  int stall = 0;
  bit clr_mode = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 0; mem_rsp_valid = 0; clr_by_rsp = 0; lat_cnt = -1;
    end else begin
      mem_rsp_valid = 0;
      clr_by_rsp = 0;
      if (lat_cnt == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data = mem_word(pend_addr);
        clr_by_rsp = clr_mode;
        lat_cnt = -1;
      end else if (lat_cnt > 0) lat_cnt--;
      stall++;
      mem_req_ready = (stall % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        pend_addr = mem_req_addr;
        lat_cnt = int'(mem_req_addr[4:2]) % 3;
        rd_log[rd_total % 4] = mem_req_addr;
        rd_total++;
      end
    end
  end

  logic [31:0] last_l1 = 0, last_l2 = 0;

  task automatic do_walk(input logic [31:0] va, input int m, input bit swap);
    int base, n, nrd;
    logic [11:0] idx;
    logic [31:0] d, pa_addr, p;
    logic [17:0] exp_st;
    base = rd_total;
    idx = va[31:20];
    d = dte_word(idx);
    pa_addr = {d[31:10], va[19:12], 2'b00};
    p = pte_word(pa_addr);
    @(negedge clk);
    while (!walk_ready) @(negedge clk);
    walk_valid = 1; walk_va = va; walk_master = 3'(m);
    @(negedge clk);
    walk_valid = 0;
    if (swap) ttb_base = 32'hDEAD_0000;
    n = 0;
    while (!res_valid && n < 100) begin @(negedge clk); n++; end
    chk("R7 walk completes", {31'd0, res_valid}, 32'd1);
    chk("R7 busy during result", {31'd0, walk_ready}, 32'd0);
    nrd = rd_total - base;
    chk("R2 first read addr", rd_log[base % 4], TTB + {18'd0, idx, 2'b00});
    exp_st = '0;
    if (d[1:0] != 2'b01) begin
      chk("R5 single read", nrd, 1);
      chk("R5 fault flag", {31'd0, res_fault}, 32'd1);
      exp_st[16] = 1; exp_st[m] = 1;
      last_l1 = va;
      chk("R5 err master", {29'd0, err_master}, m);
    end else begin
      chk("R3 two reads", nrd, 2);
      chk("R3 second read addr", rd_log[(base + 1) % 4], pa_addr);
      if (!p[1]) begin
        chk("R6 fault flag", {31'd0, res_fault}, 32'd1);
        exp_st[17] = 1; exp_st[m] = 1;
        last_l2 = va;
        chk("R6 err master", {29'd0, err_master}, m);
      end else begin
        chk("R4 fault flag", {31'd0, res_fault}, 32'd0);
        chk("R4 physical address", res_pa, {p[31:12], va[11:0]});
        chk("R4 permission", {28'd0, res_perm}, {28'd0, p[7:4]});
      end
    end
    chk("R5/R6 status", {14'd0, int_status}, {14'd0, exp_st});
    chk("R10 err l1", err_addr_l1, last_l1);
    chk("R10 err l2", err_addr_l2, last_l2);
    ttb_base = TTB;
    clr_by_task = 1; task_mask = '1;
    @(negedge clk);
    clr_by_task = 0;
    chk("R8 cleared", {14'd0, int_status}, 32'd0);
    chk("R8 irq low", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 walk_ready", {31'd0, walk_ready}, 32'd1);
    chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 status", {14'd0, int_status}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 master_run_n", {26'd0, master_run_n}, 32'h3F);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 256; k++) begin
      logic [31:0] va;
      va = {12'(k * 37), 8'(k * 13), 12'(k * 123 + 7)};
      clr_mode = (k % 8) == 5;
      do_walk(va, k % NM, (k % 16) == 7);
    end
    clr_mode = 0;

    // R8 partial clear keeps other bits; irq follows
    do_walk(32'h0000_0000, 0, 0);
    do_walk(32'h0000_0000, 4, 0);
    @(negedge clk);
    while (!walk_ready) @(negedge clk);
    walk_valid = 1; walk_va = 32'h0020_0000; walk_master = 3'd3;
    @(negedge clk); walk_valid = 0;
    while (!res_valid) @(negedge clk);
    chk("R5 status before clear", {14'd0, int_status}, 32'h0001_0008);
    clr_by_task = 1; task_mask = 18'h1_0000;
    @(negedge clk); clr_by_task = 0;
    chk("R8 partial clear", {14'd0, int_status}, 32'h0000_0008);
    chk("R8 irq with bit left", {31'd0, irq}, 32'd1);
    clr_by_task = 1; task_mask = '1;
    @(negedge clk); clr_by_task = 0;
    chk("R8 full clear", {14'd0, int_status}, 32'd0);

    // R9 master hold register
    hold_wr_valid = 1; hold_wr_data = 6'b110101;
    @(negedge clk); hold_wr_valid = 0;
    chk("R9 hold pattern", {26'd0, master_run_n}, 32'h35);
    @(negedge clk);
    chk("R9 hold retained", {26'd0, master_run_n}, 32'h35);
    hold_wr_valid = 1; hold_wr_data = '1;
    @(negedge clk); hold_wr_valid = 0;
    chk("R9 release all", {26'd0, master_run_n}, 32'h3F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule